// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Transmitter

This block sends display-controller command sequences over a three-wire serial link (clock, data out, active-low select). Bytes arrive on a valid/ready stream. Each beat carries a start marker and an end marker, which frame one sequence. The block turns every byte into a nine-bit word. The top bit of the word tells the panel whether the byte is a command or a parameter. The first byte of a sequence is the command and every later byte is a parameter.

Each word is framed by its own select-low window. The clock idles high and the panel samples data on the rising clock edge (SPI mode 3). When a sequence finishes, the block refuses new input for a programmable settle time, which is about 305 µs at 50 MHz by default. It then pulses a completion flag.

An empty sequence is sent as a single marker-only beat and is passed over with no effect. A framing fault does three things: it pulses an error flag, it discards the rest of the faulty sequence, and it suppresses the completion pulse.

Top module: `panel_cmd_tx`

## Requirements
- R1: Every word is exactly 9 bits, shifted most significant bit first, starting with bit 8. While `spi_cs_n` is low for one word there are exactly nine rising edges on `spi_sclk`, and `spi_cs_n` returns high no sooner than one half-period after the ninth rising edge.
- R2: The first byte of a sequence (the beat with `in_first`=1 and `in_void`=0) is sent with bit 8 = 0 and bits 7..0 = the byte.
- R3: Every later byte of the same sequence is sent with bit 8 = 1 and bits 7..0 = the byte.
- R4: The link runs in SPI mode 3. `spi_sclk` is high whenever `spi_cs_n` is high. `spi_mosi` changes only at a falling clock edge or while the clock is high before the first edge of a word, so it never changes at a rising edge.
- R5: After the last word of a sequence, `in_ready` stays low for `SETTLE_CYCLES` system clocks (default 15250, which is 305 µs at 50 MHz, so at least 300 µs). When the settle ends, `seq_done` pulses for one cycle, but only if the sequence had no error.
- R6: A beat with `in_first`, `in_last` and `in_void` all set, accepted while no sequence is open, is an empty sequence. It causes no select or clock activity, no settle time and no `seq_done`, and `in_ready` stays high.
- R7: A beat marked `in_first` or `in_void` while a sequence is open pulses `seq_err`. That beat and every beat up to and including the next `in_last` beat are accepted and not sent. The words already sent are still followed by a settle time, and `seq_done` does not pulse.
- R8: A beat without `in_first`, or a void beat that is not a complete empty sequence, arriving while no sequence is open, pulses `seq_err`. It and the beats up to its `in_last` beat are dropped with no bus activity and no settle time.
- R9: After reset, `spi_cs_n`=1, `spi_sclk`=1, `in_ready`=1, `seq_done`=0 and `seq_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_data | input | DATA_W | Byte to send |
| in_first | input | 1 | Beat opens a sequence |
| in_last | input | 1 | Beat closes a sequence |
| in_void | input | 1 | Beat carries no byte (empty-sequence marker) |
| in_ready | output | 1 | Block accepts a beat this cycle |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low select, low for one word |
| seq_done | output | 1 | One-cycle pulse at the end of a clean sequence's settle time |
| seq_err | output | 1 | One-cycle pulse when a framing fault is seen |

## Verification
On every cycle the assertions check the following:
- the clock is high whenever the select is high;
- the data line is stable at each rising edge;
- each select window ends only after the ninth bit;
- the controller never starts a word while dropping;
- a final word always leads into the settle state.

Some properties only the bench scenarios can show:
- the command/parameter flag on each word;
- the byte values themselves;
- the length of the settle gap in absolute time;
- that empty sequences and orphan beats leave the bus silent;
- that a mid-sequence start marker discards the tail while the bytes already sent still get their settle time.

// File: rtl/ptx_pkg.sv
// Shared state encodings for the nine-bit panel command transmitter.
package ptx_pkg;

    // Sequence controller states
    typedef enum logic [2:0] {
        C_IDLE,     // no sequence open
        C_OPEN,     // sequence open, waiting for next byte
        C_SEND,     // one word in flight on the link
        C_DROP,     // discarding beats after a framing fault
        C_SETTLE    // post-sequence hold-off
    } ctrl_st_t;

    // Word shifter states
    typedef enum logic [1:0] {
        SH_IDLE,    // select high, clock high
        SH_LEAD,    // select low, clock high, first bit presented
        SH_LOW,     // clock low phase
        SH_HIGH     // clock high phase (panel has sampled)
    } shift_st_t;

endpackage

// File: rtl/ptx_word_shifter.sv
// Word shifter: serialises one WORD_W-bit word in SPI mode 3.
// Assumes: load is only raised while busy is low. Each clock phase lasts
// HALF_CYCLES system clocks. The select drops on load and rises one
// half-period after the last rising edge.
module ptx_word_shifter
    import ptx_pkg::*;
#(
    parameter int WORD_W      = 9,
    parameter int HALF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              wdone,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int HC_W  = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [HC_W-1:0]  HALF_LAST = HC_W'(HALF_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(WORD_W - 1);

    shift_st_t          st;
    logic [WORD_W-1:0]  sh;
    logic [BIT_W-1:0]   bitn;
    logic [HC_W-1:0]    tcnt;
    logic               sclk_q;
    logic               cs_q;
    logic               wdone_q;
    logic               half_end;

    // End of the current clock phase
    assign half_end = (tcnt == HALF_LAST);

    // Phase sequencing, shifting and select control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            sh      <= '0;
            bitn    <= '0;
            tcnt    <= '0;
            sclk_q  <= 1'b1;
            cs_q    <= 1'b1;
            wdone_q <= 1'b0;
        end else begin
            wdone_q <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (load) begin
                        sh     <= word;
                        cs_q   <= 1'b0;
                        sclk_q <= 1'b1;
                        bitn   <= '0;
                        tcnt   <= '0;
                        st     <= SH_LEAD;
                    end
                end
                SH_LEAD: begin
                    if (half_end) begin
                        sclk_q <= 1'b0;
                        tcnt   <= '0;
                        st     <= SH_LOW;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SH_LOW: begin
                    if (half_end) begin
                        sclk_q <= 1'b1;
                        tcnt   <= '0;
                        st     <= SH_HIGH;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                SH_HIGH: begin
                    if (half_end) begin
                        tcnt <= '0;
                        if (bitn == BIT_LAST) begin
                            cs_q    <= 1'b1;
                            wdone_q <= 1'b1;
                            st      <= SH_IDLE;
                        end else begin
                            sclk_q <= 1'b0;
                            sh     <= {sh[WORD_W-2:0], 1'b0};
                            bitn   <= bitn + 1'b1;
                            st     <= SH_LOW;
                        end
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    assign busy  = (st != SH_IDLE);
    assign wdone = wdone_q;
    assign sclk  = sclk_q;
    assign mosi  = sh[WORD_W-1];
    assign cs_n  = cs_q;

    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |-> sclk_q); // R4
    AST_DATA_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $stable(sh[WORD_W-1])); // R4
    AST_NINE_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_q) |-> ($past(bitn) == BIT_LAST)); // R1
    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (st == SH_IDLE)); // R1

endmodule

// File: rtl/ptx_settle_timer.sv
// Settle timer: after a start pulse, stays busy for SETTLE_CYCLES clocks
// and raises fin in the last of them.
// Assumes: start is only raised while not busy.
module ptx_settle_timer #(
    parameter int SETTLE_CYCLES = 15250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fin
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             busy_q;

    // Last cycle of the hold-off window
    assign fin  = busy_q && (cnt == CNT_LAST);
    assign busy = busy_q;

    // Hold-off window counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt    <= '0;
        end else if (busy_q) begin
            if (fin) busy_q <= 1'b0;
            else     cnt    <= cnt + 1'b1;
        end
    end

    AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_q); // R5

endmodule

// File: rtl/ptx_seq_ctrl.sv
// Sequence controller: frames input beats into command/parameter words,
// detects framing faults, drops faulty tails and starts the settle timer.
// Assumes: the shifter is idle whenever this block is in C_IDLE or C_OPEN.
module ptx_seq_ctrl
    import ptx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_void,
    output logic              in_ready,
    output logic              load,
    output logic [DATA_W:0]   load_word,
    input  logic              sh_busy,
    input  logic              wdone,
    output logic              tim_start,
    input  logic              tim_fin,
    output logic              seq_done,
    output logic              seq_err
);
    ctrl_st_t st;
    logic     pend_last;
    logic     sent_any;
    logic     err_seq;
    logic     done_q;
    logic     err_q;
    logic     acc;
    logic     fault_open;

    // Beat handshake and open-sequence fault
    assign in_ready   = (st == C_IDLE) || (st == C_OPEN) || (st == C_DROP);
    assign acc        = in_valid && in_ready;
    assign fault_open = in_first || in_void;

    // Word formation: command flag clear on the opening byte only
    always_comb begin
        load      = 1'b0;
        load_word = {1'b1, in_data};
        if (st == C_IDLE && acc && in_first && !in_void) begin
            load      = 1'b1;
            load_word = {1'b0, in_data};
        end else if (st == C_OPEN && acc && !fault_open) begin
            load      = 1'b1;
        end
    end

    // Entry into the hold-off window
    assign tim_start = (st == C_SEND && wdone && pend_last)
                    || (st == C_OPEN && acc && fault_open && in_last)
                    || (st == C_DROP && acc && in_last && sent_any);

    // Sequence state, fault tracking and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= C_IDLE;
            pend_last <= 1'b0;
            sent_any  <= 1'b0;
            err_seq   <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (acc) begin
                        if (in_first && in_last && in_void) begin
                            st <= C_IDLE;
                        end else if (in_first && !in_void) begin
                            st        <= C_SEND;
                            pend_last <= in_last;
                            sent_any  <= 1'b1;
                            err_seq   <= 1'b0;
                        end else begin
                            err_q    <= 1'b1;
                            err_seq  <= 1'b1;
                            sent_any <= 1'b0;
                            st       <= in_last ? C_IDLE : C_DROP;
                        end
                    end
                end
                C_OPEN: begin
                    if (acc) begin
                        if (fault_open) begin
                            err_q   <= 1'b1;
                            err_seq <= 1'b1;
                            st      <= in_last ? C_SETTLE : C_DROP;
                        end else begin
                            pend_last <= in_last;
                            st        <= C_SEND;
                        end
                    end
                end
                C_SEND: begin
                    if (wdone) st <= pend_last ? C_SETTLE : C_OPEN;
                end
                C_DROP: begin
                    if (acc && in_last) st <= sent_any ? C_SETTLE : C_IDLE;
                end
                C_SETTLE: begin
                    if (tim_fin) begin
                        done_q <= !err_seq;
                        st     <= C_IDLE;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    assign seq_done = done_q;
    assign seq_err  = err_q;

    AST_LAST_WORD_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_SEND && wdone && pend_last) |=> (st == C_SETTLE)); // R5
    AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(tim_fin)); // R5
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_DROP) |-> !sh_busy); // R7
    AST_VOID_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_void) |-> !load); // R6

endmodule

// File: rtl/panel_cmd_tx.sv
// Top: nine-bit serial panel command transmitter. It connects the sequence
// controller, the mode-3 word shifter and the post-sequence settle timer.
// Assumes: a single clock domain. The link timing is set in system clocks
// by HALF_CYCLES (clock half-period) and SETTLE_CYCLES (hold-off).
module panel_cmd_tx #(
    parameter int DATA_W        = 8,
    parameter int HALF_CYCLES   = 4,
    parameter int SETTLE_CYCLES = 15250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_void,
    output logic              in_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_cs_n,
    output logic              seq_done,
    output logic              seq_err
);
    localparam int WORD_W = DATA_W + 1;

    logic              load;
    logic [WORD_W-1:0] load_word;
    logic              sh_busy;
    logic              wdone;
    logic              tim_start;
    logic              tim_busy;
    logic              tim_fin;

    ptx_seq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_first  (in_first),
        .in_last   (in_last),
        .in_void   (in_void),
        .in_ready  (in_ready),
        .load      (load),
        .load_word (load_word),
        .sh_busy   (sh_busy),
        .wdone     (wdone),
        .tim_start (tim_start),
        .tim_fin   (tim_fin),
        .seq_done  (seq_done),
        .seq_err   (seq_err)
    );

    ptx_word_shifter #(.WORD_W(WORD_W), .HALF_CYCLES(HALF_CYCLES)) shift_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .word  (load_word),
        .busy  (sh_busy),
        .wdone (wdone),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n)
    );

    ptx_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) settle_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tim_start),
        .busy  (tim_busy),
        .fin   (tim_fin)
    );

    AST_NO_WORD_WHILE_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
        tim_busy |-> spi_cs_n); // R5

endmodule

// File: tb/panel_cmd_tx_tb_top.sv
// Bench: random and directed command sequences, with a link monitor that
// rebuilds words and is compared against expectations built here.
module panel_cmd_tx_tb_top;
    localparam int SETTLE = 15250;
    localparam int MIN_GAP = 15000;   // 300 us at 50 MHz
    localparam int MAX_GAP = 15400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_first = 1'b0;
    logic       in_last = 1'b0;
    logic       in_void = 1'b0;
    logic       in_ready, spi_sclk, spi_mosi, spi_cs_n, seq_done, seq_err;

    always #10 clk = ~clk;   // 50 MHz

    panel_cmd_tx #(.DATA_W(8), .HALF_CYCLES(4), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .in_void(in_void),
        .in_ready(in_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .seq_done(seq_done), .seq_err(seq_err)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    // Monitor state
    logic [8:0] obs_w [0:63];
    int         obs_b [0:63];
    int         obs_n = 0;
    logic [8:0] shreg = '0;
    int         bits = 0;
    int         last_rise = 0;
    int         r4_bad = 0;
    int         done_cnt = 0;
    int         err_cnt = 0;
    logic       p_sclk = 1'b1, p_mosi = 1'b0, p_cs = 1'b1;

    // Expected words
    logic [8:0] exp_w [0:63];
    int         exp_n = 0;
    int         cmp_i = 0;

    function automatic logic [8:0] mk_word(input logic [7:0] b, input int pos);
        return {(pos != 0), b};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 195000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected=<195000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Link monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n && spi_sclk && !p_sclk) begin
                shreg = {shreg[7:0], spi_mosi};
                bits++;
                if (spi_mosi != p_mosi) r4_bad++;
            end
            if (spi_cs_n && !spi_sclk) r4_bad++;
            if (p_cs && !spi_cs_n) bits = 0;
            if (!p_cs && spi_cs_n && obs_n < 64) begin
                obs_w[obs_n] = shreg;
                obs_b[obs_n] = bits;
                obs_n++;
                last_rise = cyc;
            end
            if (seq_done) done_cnt++;
            if (seq_err)  err_cnt++;
        end
        p_sclk = spi_sclk;
        p_mosi = spi_mosi;
        p_cs   = spi_cs_n;
    end

    task automatic drive(input logic [7:0] b, input bit f, input bit l, input bit v);
        bit hs;
        @(negedge clk);
        in_valid = 1'b1; in_data = b; in_first = f; in_last = l; in_void = v;
        forever begin
            hs = in_ready;
            @(posedge clk);
            if (hs) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; in_void = 1'b0;
    endtask

    task automatic compare_words();
        for (int i = cmp_i; i < exp_n; i++) begin
            if (i >= obs_n) begin
                chk(0, "R1", "word missing", obs_n, i + 1);
            end else begin
                chk(obs_b[i] == 9, "R1", "rising edges per word", obs_b[i], 9);
                if (exp_w[i][8] == 1'b0)
                    chk(obs_w[i] == exp_w[i], "R2", "command word", obs_w[i], exp_w[i]);
                else
                    chk(obs_w[i] == exp_w[i], "R3", "parameter word", obs_w[i], exp_w[i]);
            end
        end
        chk(obs_n == exp_n, "R1", "word count", obs_n, exp_n);
        cmp_i = exp_n;
    endtask

    // Wait for the hold-off to finish and check its length and outcome
    task automatic wait_settle(input int done0, input bit clean);
        int gap;
        while (!in_ready) @(negedge clk);
        gap = cyc - last_rise;
        chk(gap >= MIN_GAP && gap <= MAX_GAP, "R5", "settle gap cycles", gap, SETTLE);
        repeat (2) @(negedge clk);
        chk(done_cnt == done0 + (clean ? 1 : 0), "R5", "done pulses", done_cnt,
            done0 + (clean ? 1 : 0));
    endtask

    task automatic run_seq(input int n, input bit rnd, input logic [7:0] b0);
        int d0;
        logic [7:0] b;
        d0 = done_cnt;
        for (int i = 0; i < n; i++) begin
            b = (i == 0 && !rnd) ? b0 : 8'($urandom);
            exp_w[exp_n] = mk_word(b, i);
            exp_n++;
            drive(b, i == 0, i == n - 1, 1'b0);
        end
        wait_settle(d0, 1'b1);
        compare_words();
    endtask

    initial begin
        int d0, e0, o0;
        void'($urandom(32'h5EED_0C0D));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(spi_cs_n && spi_sclk, "R9", "idle select/clock", {spi_cs_n, spi_sclk}, 3);
        chk(in_ready && !seq_done && !seq_err, "R9", "ready/done/err",
            {in_ready, seq_done, seq_err}, 4);

        // Directed: single-byte command
        run_seq(1, 1'b0, 8'hA5);
        // Random sequences
        for (int k = 0; k < 3; k++) run_seq(2 + int'($urandom % 5), 1'b1, 8'h00);

        // R6: empty sequence
        d0 = done_cnt; e0 = err_cnt; o0 = obs_n;
        drive(8'h00, 1'b1, 1'b1, 1'b1);
        repeat (3) begin
            chk(in_ready && spi_cs_n, "R6", "empty sequence leaves link idle",
                {in_ready, spi_cs_n}, 3);
            @(negedge clk);
        end
        chk(obs_n == o0 && done_cnt == d0 && err_cnt == e0, "R6",
            "empty sequence no words/done/err", obs_n - o0 + done_cnt - d0, 0);

        // R7: start marker inside an open sequence
        d0 = done_cnt; e0 = err_cnt;
        exp_w[exp_n] = mk_word(8'h11, 0); exp_n++;
        drive(8'h11, 1'b1, 1'b0, 1'b0);
        exp_w[exp_n] = mk_word(8'h22, 1); exp_n++;
        drive(8'h22, 1'b0, 1'b0, 1'b0);
        drive(8'h33, 1'b1, 1'b0, 1'b0);
        drive(8'h44, 1'b0, 1'b1, 1'b0);
        wait_settle(d0, 1'b0);
        chk(err_cnt == e0 + 1, "R7", "error pulse count", err_cnt, e0 + 1);
        compare_words();

        // R8: orphan beats with no open sequence
        d0 = done_cnt; e0 = err_cnt; o0 = obs_n;
        drive(8'h55, 1'b0, 1'b0, 1'b0);
        drive(8'h66, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk(in_ready, "R8", "no settle after orphan", in_ready, 1);
        repeat (40) @(negedge clk);
        chk(obs_n == o0 && spi_cs_n, "R8", "orphan beats not sent", obs_n, o0);
        chk(err_cnt == e0 + 1 && done_cnt == d0, "R8", "orphan err/done",
            err_cnt - e0, 1);

        // Recovery with a random sequence
        run_seq(3, 1'b1, 8'h00);

        // R4: mode-3 link behaviour over the whole run
        chk(r4_bad == 0, "R4", "mosi change at rise or clock low while idle", r4_bad, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule